// File: doc/BRIEF.md
# Registered 4-bit Function-Table ALU

This block is a small arithmetic logic unit with thirty-two operations. A four-bit select chooses one operation. A mode bit decides whether that operation is a bitwise logic function or an arithmetic function. Each operand bit forms a propagate term and a generate term, and the same select lines shape both terms. The arithmetic result is the bitwise half-sum combined with carries from a full look-ahead network. In logic mode the half-sum is inverted and the carries are ignored. The carry input and carry output are active low. The block also drives group propagate and group generate outputs, both active low, so that an outside look-ahead unit can combine several such slices.

Every input and every output passes through a flip-flop on the same clock. A value placed on the inputs is captured at one rising edge. The matching result appears on the outputs after the next rising edge. The outputs hold their value until a new result is captured. The reset is asynchronous and active low, and it clears every register.

Top module: `alu181_reg`

## Requirements
- R1: Inputs are captured at a rising clock edge, and the matching outputs appear after the following rising edge. With inputs held steady, the outputs stay steady.
- R2: While `rst_n` is low, every output reads zero: `f_o`=0000, `carry_n_o`=0, `grp_p_n_o`=0, `grp_g_n_o`=0, `eq_o`=0.
- R3: With `mode_i`=1, `f_o` depends on `sel_i` as follows. 0000 gives ~A. 0001 gives ~(A|B). 0010 gives ~A&B. 0011 gives 0000. 0100 gives ~(A&B). 0101 gives ~B. 0110 gives A^B. 0111 gives A&~B. 1000 gives ~A|B. 1001 gives ~(A^B). 1010 gives B. 1011 gives A&B. 1100 gives 1111. 1101 gives A|~B. 1110 gives A|B. 1111 gives A.
- R4: With `mode_i`=1, the value of `carry_n_i` has no effect on `f_o`.
- R5: With `mode_i`=0 and `carry_n_i`=1, `f_o` is the low four bits of X+Y. The pair (X,Y) depends on `sel_i` as follows. 0000 gives (A,0). 0001 gives (A|B,0). 0010 gives (A|~B,0). 0011 gives (1111,0). 0100 gives (A,A&~B). 0101 gives (A|B,A&~B). 0110 gives (A,~B). 0111 gives (A&~B,1111). 1000 gives (A,A&B). 1001 gives (A,B). 1010 gives (A|~B,A&B). 1011 gives (A&B,1111). 1100 gives (A,A). 1101 gives (A|B,A). 1110 gives (A|~B,A). 1111 gives (A,1111).
- R6: With `mode_i`=0 and `carry_n_i`=0, `f_o` is the low four bits of X+Y+1.
- R7: In both modes, `carry_n_o` is low exactly when X+Y+(~`carry_n_i`) is 16 or more.
- R8: `grp_p_n_o` is low exactly when X|Y equals 1111.
- R9: `grp_g_n_o` is low exactly when X+Y is 16 or more. As a result, when `carry_n_i`=1, `carry_n_o` equals `grp_g_n_o`.
- R10: `eq_o` is high exactly when `f_o` is 1111, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | 4 | Operand A |
| b_i | input | 4 | Operand B |
| sel_i | input | 4 | Function select |
| mode_i | input | 1 | 1 = logic functions, 0 = arithmetic functions |
| carry_n_i | input | 1 | Active-low carry input |
| f_o | output | 4 | Registered result |
| carry_n_o | output | 1 | Registered active-low carry output |
| grp_p_n_o | output | 1 | Registered active-low group propagate |
| grp_g_n_o | output | 1 | Registered active-low group generate |
| eq_o | output | 1 | Registered flag, high when the result is all ones |

## Verification
The bench runs every select value in both modes and with both carry-in levels, using operands that reach the carry chain. The following design faults are each caught by at least one comparison:
- A swapped pair of select lines, or a look-ahead term that skips a propagate factor, gives a wrong sum or carry on `sel_i`=0110, 1100 and 1111.
- A carry-in polarity error shows up as an off-by-one result on every arithmetic function.
- Carries leaking into logic mode show up as different logic results for the two carry-in levels.
- A wrong group term shows up on the all-propagate operands, where only the carry input sets the carry out.
- An extra or missing pipeline stage shifts every scoreboard comparison by one cycle.

// File: rtl/alu181_pkg.sv
package alu181_pkg;
  localparam int unsigned SEL_W = 4;

  typedef enum logic {
    MODE_ARITH = 1'b0,
    MODE_LOGIC = 1'b1
  } alu_mode_e;
endpackage

// File: rtl/alu181_bitslice.sv
module alu181_bitslice #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0]                   a_i,
  input  logic [W-1:0]                   b_i,
  input  logic [alu181_pkg::SEL_W-1:0]   sel_i,
  output logic [W-1:0]                   prop_o,
  output logic [W-1:0]                   gen_o,
  output logic [W-1:0]                   half_o
);
  // Per-bit terms: select bits 0/1 shape propagate, bits 2/3 shape generate.
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic p_bit;
    logic g_bit_w;
    always_comb begin
      p_bit   = a_i[i] | (b_i[i] & sel_i[0]) | (~b_i[i] & sel_i[1]);
      g_bit_w = (a_i[i] & ~b_i[i] & sel_i[2]) | (a_i[i] & b_i[i] & sel_i[3]);
    end
    assign prop_o[i] = p_bit;
    assign gen_o[i]  = g_bit_w;
    // Generate never exceeds propagate, so the half-sum is p AND NOT g.
    assign half_o[i] = p_bit ^ g_bit_w;
  end

  always_comb begin
    AST_GEN_IMPLIES_PROP: assert ((gen_o & ~prop_o) == '0); // R5
  end
endmodule

// File: rtl/alu181_lookahead.sv
module alu181_lookahead #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] prop_i,
  input  logic [W-1:0] gen_i,
  input  logic         cin_i,
  output logic [W-1:0] carry_o,
  output logic         cout_o,
  output logic         grp_p_o,
  output logic         grp_g_o
);
  // Flat look-ahead: carry into bit idx from all lower generates and cin.
  function automatic logic la_carry(input logic [W-1:0] p, input logic [W-1:0] g,
                                    input logic c0, input int idx);
    logic acc;
    logic term;
    acc  = 1'b0;
    term = c0;
    for (int j = 0; j < W; j++) begin
      if (j < idx) term = term & p[j];
    end
    acc = term;
    for (int j = 0; j < W; j++) begin
      if (j < idx) begin
        term = g[j];
        for (int k = 0; k < W; k++) begin
          if (k > j && k < idx) term = term & p[k];
        end
        acc = acc | term;
      end
    end
    return acc;
  endfunction

  for (genvar i = 0; i < W; i++) begin : g_carry
    assign carry_o[i] = la_carry(prop_i, gen_i, cin_i, i);
  end

  assign cout_o  = la_carry(prop_i, gen_i, cin_i, W);
  assign grp_g_o = la_carry(prop_i, gen_i, 1'b0, W);
  assign grp_p_o = &prop_i;

  always_comb begin
    if (gen_i == '0) begin
      AST_NO_GEN_PASS: assert (cout_o == (cin_i & grp_p_o)); // R7
    end
    if (!cin_i) begin
      AST_GRP_G_MATCH: assert (cout_o == grp_g_o); // R9
    end
  end
endmodule

// File: rtl/alu181_reg.sv
module alu181_reg #(
  parameter int unsigned W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [W-1:0]                  a_i,
  input  logic [W-1:0]                  b_i,
  input  logic [alu181_pkg::SEL_W-1:0]  sel_i,
  input  logic                          mode_i,
  input  logic                          carry_n_i,
  output logic [W-1:0]                  f_o,
  output logic                          carry_n_o,
  output logic                          grp_p_n_o,
  output logic                          grp_g_n_o,
  output logic                          eq_o
);
  import alu181_pkg::*;

  localparam int unsigned IN_W  = 2 * W + SEL_W + 2;
  localparam int unsigned OUT_W = W + 4;

  // Input stage
  logic [IN_W-1:0]  in_d, in_q;
  logic [W-1:0]     a_q, b_q;
  logic [SEL_W-1:0] sel_q;
  alu_mode_e        mode_q;
  logic             cin_n_q;

  always_comb in_d = {a_i, b_i, sel_i, mode_i, carry_n_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_q <= '0;
    else        in_q <= in_d;
  end

  always_comb begin
    {a_q, b_q, sel_q} = in_q[IN_W-1:2];
    mode_q            = alu_mode_e'(in_q[1]);
    cin_n_q           = in_q[0];
  end

  // Datapath
  logic [W-1:0] prop, gen, half, carry;
  logic         cout, grp_p, grp_g;
  logic [W-1:0] f_d;

  alu181_bitslice #(.W(W)) u_slice (
    .a_i(a_q), .b_i(b_q), .sel_i(sel_q),
    .prop_o(prop), .gen_o(gen), .half_o(half)
  );

  alu181_lookahead #(.W(W)) u_cla (
    .prop_i(prop), .gen_i(gen), .cin_i(~cin_n_q),
    .carry_o(carry), .cout_o(cout), .grp_p_o(grp_p), .grp_g_o(grp_g)
  );

  always_comb begin
    if (mode_q == MODE_LOGIC) f_d = ~half;
    else                      f_d = half ^ carry;
  end

  // Output stage
  logic [OUT_W-1:0] out_d, out_q;

  always_comb out_d = {f_d, ~cout, ~grp_p, ~grp_g, &f_d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign {f_o, carry_n_o, grp_p_n_o, grp_g_n_o, eq_o} = out_q;

  // Checks on registered behaviour
  AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ARITH && sel_q == 4'b1001 && cin_n_q)
    |=> ({~carry_n_o, f_o} == ($past({1'b0, a_q}) + $past({1'b0, b_q})))); // R5

  AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ARITH && sel_q == 4'b1100 && cin_n_q)
    |=> (f_o == ($past(a_q) << 1) && carry_n_o == ~$past(a_q[W-1]))); // R5

  AST_LOGIC_AND: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_LOGIC && sel_q == 4'b1011)
    |=> (f_o == ($past(a_q) & $past(b_q)))); // R3

  AST_LOGIC_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_LOGIC && sel_q == 4'b1100)
    |=> (f_o == '1 && eq_o)); // R10

  AST_COUT_IS_GRP_G: assert property (@(posedge clk) disable iff (!rst_n)
    cin_n_q |=> (carry_n_o == grp_g_n_o)); // R9

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(in_q) && $past(rst_n)) |=> $stable(out_q)); // R1
endmodule

// File: tb/sim_alu181_reg.sv
`timescale 1ns/1ps
module sim_alu181_reg;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [3:0]   sel_i = '0;
  logic         mode_i = 1'b0, carry_n_i = 1'b1;
  logic [W-1:0] f_o;
  logic         carry_n_o, grp_p_n_o, grp_g_n_o, eq_o;

  always #2 clk = ~clk;

  alu181_reg #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .sel_i(sel_i),
    .mode_i(mode_i), .carry_n_i(carry_n_i), .f_o(f_o), .carry_n_o(carry_n_o),
    .grp_p_n_o(grp_p_n_o), .grp_g_n_o(grp_g_n_o), .eq_o(eq_o)
  );

  typedef struct {
    logic [3:0] f;
    logic       cn, pn, gn, eq;
    int         due;
    string      tag;
  } exp_t;

  exp_t queue_q[$];
  int   cyc = 0;
  int   n_tests = 0, n_fail = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Behavioural reference written from the requirement tables.
  function automatic exp_t model(input logic [3:0] a, input logic [3:0] b,
                                 input logic [3:0] s, input logic m, input logic cn);
    exp_t r;
    logic [3:0] x, y, lf;
    logic [4:0] sum0, sum1;
    case (s)
      4'd0:  begin x = a;      y = 4'h0;   end
      4'd1:  begin x = a | b;  y = 4'h0;   end
      4'd2:  begin x = a | ~b; y = 4'h0;   end
      4'd3:  begin x = 4'hF;   y = 4'h0;   end
      4'd4:  begin x = a;      y = a & ~b; end
      4'd5:  begin x = a | b;  y = a & ~b; end
      4'd6:  begin x = a;      y = ~b;     end
      4'd7:  begin x = a & ~b; y = 4'hF;   end
      4'd8:  begin x = a;      y = a & b;  end
      4'd9:  begin x = a;      y = b;      end
      4'd10: begin x = a | ~b; y = a & b;  end
      4'd11: begin x = a & b;  y = 4'hF;   end
      4'd12: begin x = a;      y = a;      end
      4'd13: begin x = a | b;  y = a;      end
      4'd14: begin x = a | ~b; y = a;      end
      default: begin x = a;    y = 4'hF;   end
    endcase
    case (s)
      4'd0:  lf = ~a;        4'd1:  lf = ~(a | b);
      4'd2:  lf = ~a & b;    4'd3:  lf = 4'h0;
      4'd4:  lf = ~(a & b);  4'd5:  lf = ~b;
      4'd6:  lf = a ^ b;     4'd7:  lf = a & ~b;
      4'd8:  lf = ~a | b;    4'd9:  lf = ~(a ^ b);
      4'd10: lf = b;         4'd11: lf = a & b;
      4'd12: lf = 4'hF;      4'd13: lf = a | ~b;
      4'd14: lf = a | b;     default: lf = a;
    endcase
    sum0 = {1'b0, x} + {1'b0, y};
    sum1 = sum0 + {4'b0, ~cn};
    r.f  = m ? lf : sum1[3:0];
    r.cn = ~sum1[4];
    r.pn = ~((x | y) == 4'hF);
    r.gn = ~sum0[4];
    r.eq = (r.f == 4'hF);
    r.due = 0;
    r.tag = "";
    return r;
  endfunction

  task automatic drive(input logic [3:0] a, input logic [3:0] b, input logic [3:0] s,
                       input logic m, input logic cn, input string tag);
    exp_t e;
    @(negedge clk);
    a_i = a; b_i = b; sel_i = s; mode_i = m; carry_n_i = cn;
    e = model(a, b, s, m, cn);
    e.due = cyc + 2;
    e.tag = tag;
    queue_q.push_back(e);
  endtask

  // Monitor: compare outputs against the queue head when it falls due.
  initial begin
    forever begin
      @(posedge clk); #1;
      while (queue_q.size() > 0 && queue_q[0].due <= cyc) begin
        exp_t e;
        bit bad;
        e = queue_q.pop_front();
        bad = 0;
        n_tests++;
        if (e.due != cyc) begin
          bad = 1;
          $display("FAIL %s: result overdue at cycle %0d, expected at %0d", e.tag, cyc, e.due);
        end
        if (f_o !== e.f) begin
          bad = 1;
          $display("FAIL %s: f_o=%b expected %b", e.tag, f_o, e.f);
        end
        if (carry_n_o !== e.cn) begin
          bad = 1;
          $display("FAIL R7: carry_n_o=%b expected %b (%s)", carry_n_o, e.cn, e.tag);
        end
        if (grp_p_n_o !== e.pn) begin
          bad = 1;
          $display("FAIL R8: grp_p_n_o=%b expected %b (%s)", grp_p_n_o, e.pn, e.tag);
        end
        if (grp_g_n_o !== e.gn) begin
          bad = 1;
          $display("FAIL R9: grp_g_n_o=%b expected %b (%s)", grp_g_n_o, e.gn, e.tag);
        end
        if (eq_o !== e.eq) begin
          bad = 1;
          $display("FAIL R10: eq_o=%b expected %b (%s)", eq_o, e.eq, e.tag);
        end
        if (bad) n_fail++;
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_tests++;
    n_fail++;
    $display("FAIL R1: watchdog expired, actual=hung expected=finished");
    finish_run();
  end

  initial begin
    // R2: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_tests++;
    if ({f_o, carry_n_o, grp_p_n_o, grp_g_n_o, eq_o} !== 8'h00) begin
      n_fail++;
      $display("FAIL R2: outputs=%b expected %b", {f_o, carry_n_o, grp_p_n_o, grp_g_n_o, eq_o}, 8'h00);
    end
    rst_n = 1'b1;

    // Directed values
    drive(4'b1010, 4'b1001, 4'b0000, 1'b1, 1'b1, "R3");
    drive(4'b1010, 4'b1001, 4'b0110, 1'b1, 1'b1, "R3");
    drive(4'b1010, 4'b1001, 4'b1011, 1'b1, 1'b1, "R3");
    drive(4'b1010, 4'b1001, 4'b1110, 1'b1, 1'b1, "R3");
    drive(4'b1010, 4'b1001, 4'b1001, 1'b0, 1'b1, "R5");
    drive(4'b1010, 4'b1001, 4'b0110, 1'b0, 1'b1, "R5");
    drive(4'b1010, 4'b1001, 4'b1100, 1'b0, 1'b1, "R5");
    drive(4'b1010, 4'b1001, 4'b1111, 1'b0, 1'b1, "R5");
    // Boundaries: full propagate with and without carry in, A=B equality
    drive(4'b1111, 4'b0000, 4'b1001, 1'b0, 1'b0, "R6");
    drive(4'b1111, 4'b0000, 4'b1001, 1'b0, 1'b1, "R7");
    drive(4'b0101, 4'b0101, 4'b0110, 1'b0, 1'b1, "R10");
    drive(4'b0000, 4'b0000, 4'b1111, 1'b0, 1'b0, "R6");
    drive(4'b1000, 4'b1000, 4'b1001, 1'b0, 1'b1, "R9");

    // R1: hold inputs; outputs must repeat every cycle
    for (int k = 0; k < 4; k++) drive(4'b0110, 4'b0011, 4'b1001, 1'b0, 1'b0, "R1");

    // Full sweep: every function, both modes and both carry-in levels
    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 2; m++) begin
        for (int c = 0; c < 2; c++) begin
          for (int k = 0; k < 4; k++) begin
            logic [3:0] ra, rb;
            string t;
            ra = 4'($urandom);
            rb = 4'($urandom);
            if (m == 1) t = (c == 0) ? "R4" : "R3";
            else        t = (c == 0) ? "R6" : "R5";
            drive(ra, rb, 4'(s), 1'(m), 1'(c), t);
          end
        end
      end
    end

    repeat (4) @(posedge clk);
    #1;
    finish_run();
  end
endmodule